// File: doc/BRIEF.md
# Shared Two-Port Memory with Collision Arbiter

This block is a 1024-word by 8-bit storage array that two agents, called left and right, can use at once. Each side has its own active-low select, a read/write strobe (low writes), an active-low output enable, a 10-bit address, and separate write and read data buses. The block is a single-clock synchronous model. A write commits at the clock edge. Read data is registered at the edge.

An arbiter watches the two sides. When both are selected on the same word, it grants the word to the side that was there first and raises an active-low busy flag toward the other side. The flagged side cannot write. While the owner writes, the flagged side's read register holds its last value. The owner is chosen at the first cycle of the collision and kept until the collision ends. If both sides arrive in the same cycle, left is given the word. The arrival test uses a one-cycle history of each side's select and address.

A strap input puts the block in follower mode. This lets several copies share the arbitration of one leader copy to build a wider word. In this mode the busy outputs stay high, and each side's write inhibit and read hold come from an external active-low busy input.

Arbiter state machine (states `ARB_IDLE`, `ARB_LEFT_OWNS`, `ARB_RIGHT_OWNS`):

| From | To | Condition |
|---|---|---|
| `ARB_IDLE` | `ARB_RIGHT_OWNS` | collision, right side settled on the word, left side not settled |
| `ARB_IDLE` | `ARB_LEFT_OWNS` | any other collision, including simultaneous arrival |
| `ARB_LEFT_OWNS` or `ARB_RIGHT_OWNS` | `ARB_IDLE` | the addresses differ, or either side is deselected |
| any | same | otherwise |

A side is "settled" when it was selected on the same address in the previous cycle. A collision means both sides are selected on equal addresses.

Top module: `shared_ram_arbiter`

## Requirements
- R1: A side writes `wdata` to `addr` at the clock edge when select is low, read/write is low, and the side is not blocked. A read, with select low and read/write high, loads the word into `rdata` at the clock edge.
- R2: `drive` is 1 exactly when select is low, output enable is low and read/write is high, in the same cycle.
- R3: The two sides can access different words in the same cycle, each independently. They can also read the same word in the same cycle, and both receive its value.
- R4: In leader mode, if one side is already settled on a word and the other side selects it, the newcomer's `busy_n` goes low in that same cycle. The settled side's `busy_n` stays high.
- R5: When both sides begin a collision in the same cycle, right's `busy_n` goes low and left's stays high.
- R6: `busy_n` returns high in the same cycle that the addresses differ or the owning side is deselected. It is low only during a collision.
- R7: A write from a side whose busy is active leaves memory unchanged.
- R8: While a side is busy and the other side writes, the busy side's `rdata` keeps its previous value. Once busy clears, a read loads the current word.
- R9: Ownership taken at the start of a collision is kept while the collision lasts, even when the owner switches between read and write. After the collision ends, a new collision is arbitrated afresh.
- R10: With `slave_en` = 1, both `busy_n` outputs stay high. A side whose `busy_in_n` is low has its writes inhibited.
- R11: After reset, both `busy_n` are high, both `rdata` are 0, and the arbiter is idle. Memory contents are undefined after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | 1 selects follower mode: busy is taken from the inputs |
| l_ce_n | input | 1 | Left select, active low |
| l_rw_n | input | 1 | Left read/write, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_drive | output | 1 | Left read bus is driven (0 = released) |
| l_busy_n | output | 1 | Left busy flag, active low (leader mode) |
| l_busy_in_n | input | 1 | Left external busy, active low (follower mode) |
| r_ce_n | input | 1 | Right select, active low |
| r_rw_n | input | 1 | Right read/write, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_drive | output | 1 | Right read bus is driven (0 = released) |
| r_busy_n | output | 1 | Right busy flag, active low (leader mode) |
| r_busy_in_n | input | 1 | Right external busy, active low (follower mode) |

## Verification
The hardest situation to reach is a collision that is already owned while the owner changes its read/write direction. It is followed by a break of exactly one cycle and then a fresh collision, in which the earlier loser now arrives first. The stimulus gets there by parking one side on a word for a full cycle and then bringing the other side in. It next toggles the owner's strobe for several cycles and deselects it for one cycle. It then reselects the owner, so that the ownership history is reversed. The read-hold case is built the same way: the loser's register is first loaded from a different word, so that a frozen value can be told apart from a fresh read.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_q,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Left is applied last so it wins a same-word double write (follower mode only).
    always_ff @(posedge clk) begin
        if (r_we) cells[r_addr] <= r_wdata;
        if (l_we) cells[l_addr] <= l_wdata;
    end

    assign l_q = cells[l_addr];
    assign r_q = cells[r_addr];
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_act,
    input  logic          r_act,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    output logic          l_busy,
    output logic          r_busy
);
    arb_state_t    state_q, state_d;
    logic          l_prev_act, r_prev_act;
    logic [AW-1:0] l_prev_addr, r_prev_addr;
    logic          coll, l_settled, r_settled;

    assign coll      = l_act && r_act && (l_addr == r_addr);
    assign l_settled = l_prev_act && (l_prev_addr == l_addr);
    assign r_settled = r_prev_act && (r_prev_addr == r_addr);

    // Arrival history: what each side did in the previous cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_prev_act  <= 1'b0;
            r_prev_act  <= 1'b0;
            l_prev_addr <= '0;
            r_prev_addr <= '0;
        end else begin
            l_prev_act  <= l_act;
            r_prev_act  <= r_act;
            l_prev_addr <= l_addr;
            r_prev_addr <= r_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (coll)
                    state_d = (r_settled && !l_settled) ? ARB_RIGHT_OWNS : ARB_LEFT_OWNS;
            end
            ARB_LEFT_OWNS, ARB_RIGHT_OWNS: begin
                if (!coll) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        l_busy = coll && (state_d == ARB_RIGHT_OWNS);
        r_busy = coll && (state_d == ARB_LEFT_OWNS);
    end

    AST_LEFT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |=> !l_busy); // R9
    AST_RIGHT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy |=> !r_busy); // R9
    AST_BUSY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy || r_busy) |-> (l_act && r_act && l_addr == r_addr)); // R6
    AST_LATECOMER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && coll && l_settled && !r_settled) |-> r_busy); // R4
endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          rw_n,
    input  logic          oe_n,
    input  logic          blocked,
    input  logic          peer_we,
    input  logic [DW-1:0] mem_q,
    output logic          we,
    output logic          act,
    output logic          drive,
    output logic [DW-1:0] rdata
);
    logic rd_req, hold;

    assign act    = !ce_n;
    assign we     = !ce_n && !rw_n && !blocked;
    assign rd_req = !ce_n && rw_n;
    assign hold   = blocked && peer_we;
    assign drive  = !ce_n && !oe_n && rw_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               rdata <= '0;
        else if (rd_req && !hold) rdata <= mem_q;
    end

    AST_FROZEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && peer_we) |=> $stable(rdata)); // R8
endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_en,
    input  logic          l_ce_n,
    input  logic          l_rw_n,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_drive,
    output logic          l_busy_n,
    input  logic          l_busy_in_n,
    input  logic          r_ce_n,
    input  logic          r_rw_n,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_drive,
    output logic          r_busy_n,
    input  logic          r_busy_in_n
);
    logic          l_act, r_act, l_we, r_we;
    logic          l_arb_busy, r_arb_busy, l_block, r_block;
    logic [DW-1:0] l_q, r_q;

    dpram_arbiter #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .l_act(l_act), .r_act(r_act),
        .l_addr(l_addr), .r_addr(r_addr),
        .l_busy(l_arb_busy), .r_busy(r_arb_busy)
    );

    assign l_block  = slave_en ? !l_busy_in_n : l_arb_busy;
    assign r_block  = slave_en ? !r_busy_in_n : r_arb_busy;
    assign l_busy_n = !(l_arb_busy && !slave_en);
    assign r_busy_n = !(r_arb_busy && !slave_en);

    dpram_port #(.DW(DW)) u_lport (
        .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .rw_n(l_rw_n), .oe_n(l_oe_n),
        .blocked(l_block), .peer_we(r_we), .mem_q(l_q),
        .we(l_we), .act(l_act), .drive(l_drive), .rdata(l_rdata)
    );

    dpram_port #(.DW(DW)) u_rport (
        .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .rw_n(r_rw_n), .oe_n(r_oe_n),
        .blocked(r_block), .peer_we(l_we), .mem_q(r_q),
        .we(r_we), .act(r_act), .drive(r_drive), .rdata(r_rdata)
    );

    dpram_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk),
        .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_q(l_q),
        .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_q(r_q)
    );

    AST_LEFT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        l_block |-> !l_we); // R7
    AST_RIGHT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        r_block |-> !r_we); // R7
    AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slave_en |-> (l_busy_n && r_busy_n)); // R10
    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n)); // R4
endmodule

// File: tb/tb_shared_ram_arbiter.sv
module tb_shared_ram_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_en = 1'b0;
    logic       l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1, l_busy_in_n = 1'b1;
    logic       r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1, r_busy_in_n = 1'b1;
    logic [9:0] l_addr = '0, r_addr = '0;
    logic [7:0] l_wdata = '0, r_wdata = '0;
    logic [7:0] l_rdata, r_rdata;
    logic       l_drive, r_drive, l_busy_n, r_busy_n;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    shared_ram_arbiter dut (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
        .l_busy_n(l_busy_n), .l_busy_in_n(l_busy_in_n),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive),
        .r_busy_n(r_busy_n), .r_busy_in_n(r_busy_in_n)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        l_ce_n = 1; l_rw_n = 1; l_oe_n = 1;
        r_ce_n = 1; r_rw_n = 1; r_oe_n = 1;
    endtask

    task automatic set_l(bit ce, bit rw, int a, int d);
        l_ce_n = ce; l_rw_n = rw; l_oe_n = 0; l_addr = a[9:0]; l_wdata = d[7:0];
    endtask

    task automatic set_r(bit ce, bit rw, int a, int d);
        r_ce_n = ce; r_rw_n = rw; r_oe_n = 0; r_addr = a[9:0]; r_wdata = d[7:0];
    endtask

    task automatic write_l(int a, int d);
        set_l(0, 0, a, d); tick(); idle(); tick();
    endtask

    task automatic read_l(int a, output int v);
        set_l(0, 1, a, 0); tick(); v = l_rdata; idle(); tick();
    endtask

    task automatic read_r(int a, output int v);
        set_r(0, 1, a, 0); tick(); v = r_rdata; idle(); tick();
    endtask

    task automatic t_reset();
        chk("R11 l_busy_n", l_busy_n, 1);
        chk("R11 r_busy_n", r_busy_n, 1);
        chk("R11 l_rdata", l_rdata, 0);
        chk("R11 r_rdata", r_rdata, 0);
    endtask

    task automatic t_independent();
        int v;
        set_l(0, 0, 5, 8'h3A); set_r(0, 0, 9, 8'h5C);
        #1;
        chk("R3 no busy distinct words", {l_busy_n, r_busy_n}, 2'b11);
        tick(); idle(); tick();
        set_l(0, 1, 9, 0); set_r(0, 1, 5, 0);
        tick();
        chk("R1 R3 left reads right's word", l_rdata, 8'h5C);
        chk("R1 R3 right reads left's word", r_rdata, 8'h3A);
        idle(); tick();
        read_l(5, v);
        chk("R1 left readback", v, 8'h3A);
    endtask

    task automatic t_drive();
        set_l(0, 1, 5, 0); #1;
        chk("R2 drive on read", l_drive, 1);
        l_oe_n = 1; #1;
        chk("R2 released oe high", l_drive, 0);
        l_oe_n = 0; l_rw_n = 0; l_wdata = 8'h3A; #1;
        chk("R2 released on write", l_drive, 0);
        l_rw_n = 1; l_ce_n = 1; #1;
        chk("R2 released when deselected", l_drive, 0);
        idle(); tick();
    endtask

    task automatic t_same_read();
        set_l(0, 1, 9, 0); set_r(0, 1, 9, 0); #1;
        chk("R5 simultaneous right busy", r_busy_n, 0);
        chk("R5 simultaneous left free", l_busy_n, 1);
        tick();
        chk("R3 left same-word read", l_rdata, 8'h5C);
        chk("R3 right same-word read", r_rdata, 8'h5C);
        idle(); tick();
    endtask

    task automatic t_left_first();
        int v;
        write_l(20, 8'h11);
        set_l(0, 1, 20, 0); tick();
        set_r(0, 0, 20, 8'hFF); #1;
        chk("R4 newcomer right busy", r_busy_n, 0);
        chk("R4 settled left free", l_busy_n, 1);
        tick(); idle(); tick();
        read_l(20, v);
        chk("R7 blocked write discarded", v, 8'h11);
    endtask

    task automatic t_right_first();
        int v;
        write_l(60, 8'h0F);
        set_r(0, 1, 60, 0); tick();
        set_l(0, 0, 60, 8'hAB); #1;
        chk("R4 newcomer left busy", l_busy_n, 0);
        tick();
        r_addr = 10'd61; #1;
        chk("R6 release on address mismatch", l_busy_n, 1);
        tick(); idle(); tick();
        read_r(60, v);
        chk("R6 write proceeds after release", v, 8'hAB);
    endtask

    task automatic t_read_hold();
        int v;
        write_l(31, 8'h66);
        set_r(0, 1, 31, 0); tick();
        chk("R1 right loads word 31", r_rdata, 8'h66);
        r_ce_n = 1; set_l(0, 0, 30, 8'h77); tick();
        set_l(0, 0, 30, 8'h88); set_r(0, 1, 30, 0); #1;
        chk("R8 right busy behind writer", r_busy_n, 0);
        tick();
        chk("R8 loser read held", r_rdata, 8'h66);
        l_ce_n = 1; #1;
        chk("R6 release on owner deselect", r_busy_n, 1);
        tick();
        chk("R8 read updates after release", r_rdata, 8'h88);
        idle(); tick();
        read_l(30, v);
        chk("R8 owner write landed", v, 8'h88);
    endtask

    task automatic t_priority_held();
        set_l(0, 1, 40, 0); tick();
        set_r(0, 1, 40, 0); #1;
        chk("R4 right busy on arrival", r_busy_n, 0);
        tick();
        set_l(0, 0, 40, 8'h21); #1;
        chk("R9 owner turns writer, right still busy", r_busy_n, 0);
        chk("R9 owner not busy", l_busy_n, 1);
        tick();
        set_l(0, 1, 40, 0); #1;
        chk("R9 owner back to read, right still busy", r_busy_n, 0);
        tick();
        l_ce_n = 1; #1;
        chk("R6 gap clears busy", r_busy_n, 1);
        tick();
        l_ce_n = 0; #1;
        chk("R9 rearbitrated, left now late", l_busy_n, 0);
        chk("R9 rearbitrated, right owns", r_busy_n, 1);
        tick(); idle(); tick();
    endtask

    task automatic t_follower();
        int v;
        write_l(50, 8'h12);
        slave_en = 1;
        set_l(0, 1, 70, 0); set_r(0, 1, 70, 0); #1;
        chk("R10 no busy out in follower mode", {l_busy_n, r_busy_n}, 2'b11);
        tick(); idle(); tick();
        l_busy_in_n = 0;
        set_l(0, 0, 50, 8'h99); set_r(0, 0, 51, 8'h34);
        tick(); idle(); l_busy_in_n = 1; tick();
        read_l(50, v);
        chk("R10 external busy inhibits write", v, 8'h12);
        read_l(51, v);
        chk("R10 unblocked side writes", v, 8'h34);
        slave_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_independent();
        t_drive();
        t_same_read();
        t_left_first();
        t_right_first();
        t_read_hold();
        t_priority_held();
        t_follower();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule